// File: doc/BRIEF.md
# Register-Pair Addressed Load/Store Unit

This unit runs one memory-access micro-operation at a time against a built-in file of 32 general registers. Every address comes from a register pair: pair k joins register 2k+1 (upper 32 bits) and register 2k (lower 32 bits) into a 64-bit pointer. Each access also moves the pointer by a signed step. The step is added either before the access, so the access sees the moved pointer, or after it, so the access sees the old one. The moved pointer is written back into the pair.

Accepted operations are:
- a load into a data register;
- a store of a data register;
- a store of a 16-bit or a 32-bit immediate;
- two immediate-to-register moves that never touch memory.

Memory is reached through one request channel with a valid/ready handshake and a separate read-data-valid response. A one-cycle completion pulse marks the cycle in which the register file takes its write-back. A combinational peek port exposes any register.

Top module: `pairls_unit`

## Requirements
- R1: A synchronous active-low reset clears all 32 registers to zero, raises `op_ready`, and holds `mem_req_valid` and `done` low.
- R2: With `pre_mode`=0 the request address is the pair value `{reg[2k+1],reg[2k]}` at acceptance, and after completion the pair holds that value plus the step.
- R3: With `pre_mode`=1 the request address is the pair value plus the step, and the pair holds that same value after completion.
- R4: The 16-bit step is sign-extended to 64 bits, so a negative step decrements the pair, and a carry or borrow out of the lower register reaches the upper register.
- R5: `op_kind`=0 (load) issues a request with `mem_we`=0. The word returned with `mem_rvalid` is written into register `reg_sel`.
- R6: `op_kind`=1 (store register) issues `mem_we`=1 with `mem_wdata` equal to register `reg_sel` as it stood at acceptance.
- R7: `op_kind`=2 stores `imm[15:0]` sign-extended to 32 bits, and `op_kind`=3 stores all 32 bits of `imm`. Both use `mem_we`=1.
- R8: `op_kind`=4 writes the sign-extended `imm[15:0]` into `reg_sel`, and `op_kind`=5 writes `imm` into `reg_sel`. Neither raises `mem_req_valid` nor changes any pair.
- R9: When a load's `reg_sel` is one half of the pair being stepped, that half receives the loaded word. The other half receives the stepped value.
- R10: While a request waits for `mem_req_ready`, `mem_req_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay constant. `op_ready` stays low until the operation ends.
- R11: `done` is high for exactly one cycle per operation, the cycle whose closing edge commits the write-back. `op_ready` is high in the cycle that follows.
- R12: `op_kind` codes 6 and 7 complete with a `done` pulse, issue no request and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken on this edge when valid |
| op_kind | input | 3 | Operation code (see R5 to R8, R12) |
| pair_sel | input | 4 | Address pair index k |
| pre_mode | input | 1 | 1 = step before access, 0 = step after |
| step | input | 16 | Signed pointer step |
| reg_sel | input | 5 | Data register index |
| imm | input | 32 | Immediate operand |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 64 | Request address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read word |
| done | output | 1 | Write-back committed on this edge |
| peek_sel | input | 5 | Register index to observe |
| peek_data | output | 32 | Current value of register `peek_sel` |

## Verification
The hardest case to reach is a load whose destination is a half of the pair it steps. Two writers then aim at one register on one edge, and the result is visible only after the load data has gone through a stalled response. The stimulus table first builds pair values with immediate moves. It then issues loads whose destination is the low half and the high half of their own pair, in pre and post mode and with varied memory stall lengths. Steps are chosen so that a carry and a borrow cross the 32-bit boundary, and every register involved is read back through the peek port.

// File: rtl/pairls_pkg.sv
// Shared types for the register-pair load/store unit.
// Assumes the operation code layout given in the brief.
package pairls_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STREG   = 3'd1,
        OP_STSHORT = 3'd2,
        OP_STWIDE  = 3'd3,
        OP_SETSHORT= 3'd4,
        OP_SETWIDE = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } state_e;

    // True for operations that touch memory and step the pair
    function automatic logic op_uses_mem(op_e o);
        return (o == OP_LOAD) || (o == OP_STREG) ||
               (o == OP_STSHORT) || (o == OP_STWIDE);
    endfunction

    // True for operations that write a data register
    function automatic logic op_writes_reg(op_e o);
        return (o == OP_LOAD) || (o == OP_SETSHORT) || (o == OP_SETWIDE);
    endfunction

endpackage

// File: rtl/pairls_regfile.sv
// General register file with a pair view.
// Provides a pair read port, a data read port and a peek read port, all combinational.
// Two write ports: a pair write (both halves) and a single-register write.
// Assumes at most one pair write and one register write per cycle.
// The register write wins over the pair write when both hit one register.
module pairls_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int IDX_W  = $clog2(NREG),
    localparam int PAIR_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] pair_rd_sel,
    output logic [XLEN-1:0]   pair_rd_lo,
    output logic [XLEN-1:0]   pair_rd_hi,
    input  logic [IDX_W-1:0]  data_rd_sel,
    output logic [XLEN-1:0]   data_rd,
    input  logic [IDX_W-1:0]  peek_sel,
    output logic [XLEN-1:0]   peek_data,
    input  logic              pair_we,
    input  logic [PAIR_W-1:0] pair_wr_sel,
    input  logic [XLEN-1:0]   pair_wr_lo,
    input  logic [XLEN-1:0]   pair_wr_hi,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_wr_sel,
    input  logic [XLEN-1:0]   reg_wr_data
);

    logic [XLEN-1:0] rf [NREG];

    // Read ports: pair halves, data register, peek
    always_comb begin
        pair_rd_lo = rf[{pair_rd_sel, 1'b0}];
        pair_rd_hi = rf[{pair_rd_sel, 1'b1}];
        data_rd    = rf[data_rd_sel];
        peek_data  = rf[peek_sel];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(i);
        localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(i / 2);
        localparam bit                IS_HI   = (i % 2) == 1;

        // Per-register update: reset, single write, then pair write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rf[i] <= '0;
            end else if (reg_we && (reg_wr_sel == MY_IDX)) begin
                rf[i] <= reg_wr_data;
            end else if (pair_we && (pair_wr_sel == MY_PAIR)) begin
                rf[i] <= IS_HI ? pair_wr_hi : pair_wr_lo;
            end
        end
    end

endmodule

// File: rtl/pairls_addr.sv
// Pointer stepping for one pair.
// Forms the stepped pair value as two word adds with an explicit carry
// from the lower word into the upper word, and picks the access address
// by update mode. Assumes STEP_W <= 2*XLEN.
module pairls_addr #(
    parameter int XLEN   = 32,
    parameter int STEP_W = 16,
    localparam int AW    = 2 * XLEN
) (
    input  logic [XLEN-1:0]   pair_lo,
    input  logic [XLEN-1:0]   pair_hi,
    input  logic [STEP_W-1:0] step,
    input  logic              pre_mode,
    output logic [AW-1:0]     acc_addr,
    output logic [XLEN-1:0]   next_lo,
    output logic [XLEN-1:0]   next_hi
);

    logic [AW-1:0] step_ext;
    logic [XLEN:0] lo_sum;

    // Sign-extend the step to the full pointer width
    always_comb step_ext = {{(AW-STEP_W){step[STEP_W-1]}}, step};

    // Lower-word add with carry out, upper-word add takes the carry
    always_comb begin
        lo_sum  = {1'b0, pair_lo} + {1'b0, step_ext[XLEN-1:0]};
        next_lo = lo_sum[XLEN-1:0];
        next_hi = pair_hi + step_ext[AW-1:XLEN] + {{(XLEN-1){1'b0}}, lo_sum[XLEN]};
    end

    // Access address: stepped value in pre mode, current value otherwise
    always_comb acc_addr = pre_mode ? {next_hi, next_lo} : {pair_hi, pair_lo};

endmodule

// File: rtl/pairls_seq.sv
// Operation sequencer.
// Takes one operation when idle and captures everything it needs on that
// edge: address, stepped pair and outgoing word. It then runs the memory
// handshake and commits the write-back in a single cycle flagged by done.
// Assumes mem_rvalid only arrives while a load waits for it.
module pairls_seq
    import pairls_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int XLEN   = 32,
    parameter int SIMM_W = 16,
    localparam int IDX_W  = $clog2(NREG),
    localparam int PAIR_W = IDX_W - 1,
    localparam int AW     = 2 * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_kind,
    input  logic [PAIR_W-1:0] pair_sel,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic [XLEN-1:0]   imm,
    input  logic [AW-1:0]     acc_addr,
    input  logic [XLEN-1:0]   next_lo,
    input  logic [XLEN-1:0]   next_hi,
    input  logic [XLEN-1:0]   data_rd,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              pair_we,
    output logic [PAIR_W-1:0] pair_wr_sel,
    output logic [XLEN-1:0]   pair_wr_lo,
    output logic [XLEN-1:0]   pair_wr_hi,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_wr_sel,
    output logic [XLEN-1:0]   reg_wr_data,
    output logic              done
);

    state_e             state_q;
    op_e                op_q;
    op_e                op_in;
    logic [PAIR_W-1:0]  pair_q;
    logic [IDX_W-1:0]   reg_q;
    logic [AW-1:0]      addr_q;
    logic [XLEN-1:0]    word_q;
    logic [XLEN-1:0]    nlo_q;
    logic [XLEN-1:0]    nhi_q;
    logic [XLEN-1:0]    short_ext;
    logic [XLEN-1:0]    word_in;
    logic               take;

    // Decode the incoming code and accept when idle
    always_comb begin
        op_in    = op_e'(op_kind);
        op_ready = (state_q == ST_IDLE);
        take     = op_valid && op_ready;
    end

    // Sign-extend the short immediate
    always_comb short_ext = {{(XLEN-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};

    // Select the word carried by the operation (store data or set value)
    always_comb begin
        unique case (op_in)
            OP_STREG:                word_in = data_rd;
            OP_STSHORT, OP_SETSHORT: word_in = short_ext;
            OP_STWIDE,  OP_SETWIDE:  word_in = imm;
            default:                 word_in = '0;
        endcase
    end

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take) state_q <= op_uses_mem(op_in) ? ST_REQ : ST_WB;
                ST_REQ:  if (mem_req_ready) state_q <= (op_q == OP_LOAD) ? ST_WAIT : ST_WB;
                ST_WAIT: if (mem_rvalid) state_q <= ST_WB;
                ST_WB:   state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operation fields captured on acceptance; load data captured on response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_RSV7;
            pair_q <= '0;
            reg_q  <= '0;
            addr_q <= '0;
            word_q <= '0;
            nlo_q  <= '0;
            nhi_q  <= '0;
        end else if (take) begin
            op_q   <= op_in;
            pair_q <= pair_sel;
            reg_q  <= reg_sel;
            addr_q <= acc_addr;
            word_q <= word_in;
            nlo_q  <= next_lo;
            nhi_q  <= next_hi;
        end else if ((state_q == ST_WAIT) && mem_rvalid) begin
            word_q <= mem_rdata;
        end
    end

    // Memory request outputs
    always_comb begin
        mem_req_valid = (state_q == ST_REQ);
        mem_addr      = addr_q;
        mem_we        = (op_q != OP_LOAD);
        mem_wdata     = word_q;
    end

    // Write-back outputs, active only in the commit cycle
    always_comb begin
        done        = (state_q == ST_WB);
        pair_we     = done && op_uses_mem(op_q);
        pair_wr_sel = pair_q;
        pair_wr_lo  = nlo_q;
        pair_wr_hi  = nhi_q;
        reg_we      = done && op_writes_reg(op_q);
        reg_wr_sel  = reg_q;
        reg_wr_data = word_q;
    end

endmodule

// File: rtl/pairls_unit.sv
// Register-pair addressed load/store unit, top level.
// Joins the register file, the pointer stepper and the sequencer.
// The pointer and the store word are taken from the register file in the
// acceptance cycle, so a later write-back never alters an issued request.
module pairls_unit #(
    parameter int NREG   = 32,
    parameter int XLEN   = 32,
    parameter int STEP_W = 16,
    parameter int SIMM_W = 16,
    localparam int IDX_W  = $clog2(NREG),
    localparam int PAIR_W = IDX_W - 1,
    localparam int AW     = 2 * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_kind,
    input  logic [PAIR_W-1:0] pair_sel,
    input  logic              pre_mode,
    input  logic [STEP_W-1:0] step,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic [XLEN-1:0]   imm,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    input  logic [IDX_W-1:0]  peek_sel,
    output logic [XLEN-1:0]   peek_data
);

    logic [XLEN-1:0]   pair_lo;
    logic [XLEN-1:0]   pair_hi;
    logic [XLEN-1:0]   data_rd;
    logic [AW-1:0]     acc_addr;
    logic [XLEN-1:0]   next_lo;
    logic [XLEN-1:0]   next_hi;
    logic              pair_we;
    logic [PAIR_W-1:0] pair_wr_sel;
    logic [XLEN-1:0]   pair_wr_lo;
    logic [XLEN-1:0]   pair_wr_hi;
    logic              reg_we;
    logic [IDX_W-1:0]  reg_wr_sel;
    logic [XLEN-1:0]   reg_wr_data;

    pairls_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_rd_sel (pair_sel),
        .pair_rd_lo  (pair_lo),
        .pair_rd_hi  (pair_hi),
        .data_rd_sel (reg_sel),
        .data_rd     (data_rd),
        .peek_sel    (peek_sel),
        .peek_data   (peek_data),
        .pair_we     (pair_we),
        .pair_wr_sel (pair_wr_sel),
        .pair_wr_lo  (pair_wr_lo),
        .pair_wr_hi  (pair_wr_hi),
        .reg_we      (reg_we),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data)
    );

    pairls_addr #(.XLEN(XLEN), .STEP_W(STEP_W)) u_addr (
        .pair_lo  (pair_lo),
        .pair_hi  (pair_hi),
        .step     (step),
        .pre_mode (pre_mode),
        .acc_addr (acc_addr),
        .next_lo  (next_lo),
        .next_hi  (next_hi)
    );

    pairls_seq #(.NREG(NREG), .XLEN(XLEN), .SIMM_W(SIMM_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_ready      (op_ready),
        .op_kind       (op_kind),
        .pair_sel      (pair_sel),
        .reg_sel       (reg_sel),
        .imm           (imm),
        .acc_addr      (acc_addr),
        .next_lo       (next_lo),
        .next_hi       (next_hi),
        .data_rd       (data_rd),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .pair_we       (pair_we),
        .pair_wr_sel   (pair_wr_sel),
        .pair_wr_lo    (pair_wr_lo),
        .pair_wr_hi    (pair_wr_hi),
        .reg_we        (reg_we),
        .reg_wr_sel    (reg_wr_sel),
        .reg_wr_data   (reg_wr_data),
        .done          (done)
    );

endmodule

// File: rtl/pairls_unit_chk.sv
// Protocol checker for pairls_unit, attached by bind.
// Watches the operation and memory handshakes and the completion pulse.
module pairls_unit_chk #(
    parameter int XLEN = 32,
    localparam int AW  = 2 * XLEN
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_ready,
    input logic [2:0]      op_kind,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_wdata,
    input logic            done
);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !op_ready);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_then_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> op_ready);

    p_set_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && (op_kind[2:1] == 2'b10)) |=> (!mem_req_valid && done));

    p_rsv_no_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && (op_kind[2:1] == 2'b11)) |=> (!mem_req_valid && done));

endmodule

bind pairls_unit pairls_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .op_kind       (op_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .done          (done)
);

// File: tb/pairls_unit_bench.sv
// Bench for pairls_unit: table-driven operations against a bench-side
// register model, then directed reset checks.
module pairls_unit_bench;

    localparam int NVEC = 13;
    // Entry layout: {op[2:0], pair[3:0], pre, step[15:0], reg[4:0], imm[31:0]}
    localparam logic [60:0] VEC [NVEC] = '{
        {3'd5, 4'd0, 1'b0, 16'h0000, 5'd4,  32'hFFFF_FFFC}, // wide set r4
        {3'd4, 4'd0, 1'b0, 16'h0000, 5'd5,  32'h0000_0001}, // short set r5
        {3'd3, 4'd2, 1'b0, 16'h0008, 5'd0,  32'hDEAD_BEEF}, // post +8, carry into r5
        {3'd0, 4'd2, 1'b1, 16'hFFF8, 5'd10, 32'h0},         // pre -8, borrow, load r10
        {3'd1, 4'd2, 1'b1, 16'h0004, 5'd10, 32'h0},         // pre +4, store r10
        {3'd4, 4'd0, 1'b0, 16'h0000, 5'd7,  32'h0000_8001}, // short set negative r7
        {3'd2, 4'd3, 1'b0, 16'hFFFF, 5'd0,  32'h1234_8000}, // post -1, short store neg
        {3'd0, 4'd5, 1'b0, 16'h0002, 5'd11, 32'h0},         // load into high half of own pair
        {3'd0, 4'd0, 1'b1, 16'h0010, 5'd0,  32'h0},         // pre load into low half of own pair
        {3'd6, 4'd2, 1'b1, 16'h0100, 5'd4,  32'hFFFF_FFFF}, // reserved code
        {3'd4, 4'd0, 1'b0, 16'h0000, 5'd3,  32'h0000_1234}, // short set r3
        {3'd1, 4'd1, 1'b0, 16'h0000, 5'd3,  32'h0},         // store own-pair register, step 0
        {3'd7, 4'd1, 1'b0, 16'h0040, 5'd2,  32'h5555_5555}  // reserved code
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [2:0]  op_kind = '0;
    logic [3:0]  pair_sel = '0;
    logic        pre_mode = 1'b0;
    logic [15:0] step = '0;
    logic [4:0]  reg_sel = '0;
    logic [31:0] imm = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [4:0]  peek_sel = '0;
    logic [31:0] peek_data;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model [32];

    always #2 clk = ~clk;

    pairls_unit u_pairls_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .pair_sel(pair_sel), .pre_mode(pre_mode), .step(step),
        .reg_sel(reg_sel), .imm(imm), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .peek_sel(peek_sel), .peek_data(peek_data)
    );

    function automatic logic [31:0] rd_word(logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'h5A5A_3C3C;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(string req, int idx);
        peek_sel = 5'(idx);
        #0.1;
        chk(req, {32'h0, peek_data}, {32'h0, model[idx]});
    endtask

    task automatic run_op(logic [60:0] v, int d);
        logic [2:0]  o  = v[60:58];
        logic [3:0]  p  = v[57:54];
        logic        pr = v[53];
        logic [15:0] s  = v[52:37];
        logic [4:0]  r  = v[36:32];
        logic [31:0] im = v[31:0];
        logic [63:0] old_p = {model[2*p+1], model[2*p]};
        logic [63:0] new_p = old_p + {{48{s[15]}}, s};
        logic [63:0] addr  = pr ? new_p : old_p;
        logic [31:0] sx    = {{16{im[15]}}, im[15:0]};
        logic [31:0] wexp;
        logic [31:0] ld;
        logic        mem   = (o <= 3'd3);
        wexp = (o == 3'd1) ? model[r] : (o == 3'd2) ? sx : im;
        ld   = rd_word(addr);
        @(negedge clk);
        chk("R10 op_ready idle", {63'h0, op_ready}, 64'h1);
        op_valid = 1'b1; op_kind = o; pair_sel = p; pre_mode = pr;
        step = s; reg_sel = r; imm = im;
        @(negedge clk);
        op_valid = 1'b0;
        if (mem) begin
            chk("R10 request raised", {63'h0, mem_req_valid}, 64'h1);
            chk(pr ? "R3 pre address" : "R2 post address", mem_addr, addr);
            chk("R5/R6 direction", {63'h0, mem_we}, {63'h0, (o != 3'd0)});
            if (o != 3'd0) chk(o == 3'd1 ? "R6 store data" : "R7 immediate data",
                               {32'h0, mem_wdata}, {32'h0, wexp});
            repeat (d) @(negedge clk);
            chk("R10 held address", mem_addr, addr);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            if (o == 3'd0) begin
                chk("R11 no done while waiting", {63'h0, done}, 64'h0);
                repeat (d) @(negedge clk);
                mem_rvalid = 1'b1; mem_rdata = ld;
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end else begin
            chk("R8/R12 no request", {63'h0, mem_req_valid}, 64'h0);
        end
        chk("R11 done pulse", {63'h0, done}, 64'h1);
        if (mem) begin
            model[2*p]   = new_p[31:0];
            model[2*p+1] = new_p[63:32];
        end
        if (o == 3'd0) model[r] = ld;
        if (o == 3'd4) model[r] = sx;
        if (o == 3'd5) model[r] = im;
        @(negedge clk);
        chk("R11 done single", {63'h0, done}, 64'h0);
        chk_reg("R2/R3/R4 pair low", 2*p);
        chk_reg("R2/R3/R4 pair high", 2*p+1);
        chk_reg((o == 3'd0) ? "R5/R9 load target" : "R8/R12 data register", r);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 op_ready", {63'h0, op_ready}, 64'h1);
        chk("R1 mem_req_valid", {63'h0, mem_req_valid}, 64'h0);
        chk("R1 done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) chk_reg("R1 register zero", i);
        // Table walk
        for (int i = 0; i < NVEC; i++) run_op(VEC[i], i % 3);
        // Directed: reset in the middle of a stalled store (R1)
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'd3; pair_sel = 4'd2; pre_mode = 1'b0;
        step = 16'h0001; reg_sel = 5'd0; imm = 32'hCAFE_F00D;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 request pending", {63'h0, mem_req_valid}, 64'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 request dropped", {63'h0, mem_req_valid}, 64'h0);
        chk("R1 idle after reset", {63'h0, op_ready}, 64'h1);
        for (int i = 0; i < 32; i++) model[i] = '0;
        chk_reg("R1 pair cleared", 4);
        chk_reg("R1 pair cleared", 5);
        // Directed: post step from zero with large negative step (R4)
        run_op({3'd1, 4'd15, 1'b0, 16'h8000, 5'd30, 32'h0}, 1);
        summary();
        $finish;
    end

endmodule